// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation converter with a one-wire serial result. It runs on the host's serial clock, and an active-low chip select frames each conversion. It makes all of its decisions on falling clock edges. A host that samples on rising edges therefore always sees a settled data line.

A frame lasts eleven falling edges after chip select goes low. The first three edges are a settling phase, and the data line stays low during them. On each of the next eight edges the block reads the comparator input against the trial code it is driving to the external DAC. It keeps or clears the bit under test and puts that same decision on the data line at once. The most significant bit goes first. After the last decision the trial code holds the final result and the line rests low. Raising chip select releases the line and clears every register. A new frame needs chip select to go high and then low again.

Top module: `sar_serial_seq`

## Requirements
- R1: `dout_oe` is 1 exactly while `cs_n` is 0. While `cs_n` is 1, `dout` reads 0.
- R2: Every falling `sclk` edge that sees `cs_n` high clears the sequencer. After such an edge, `trial_code` is 8'h80 (only bit 7 set) and `dout` is 0.
- R3: On falling edges 1 to 3 of a frame, counted from the first falling edge with `cs_n` low, `dout` is driven 0 and `trial_code` stays 8'h80.
- R4: On falling edge 3+k (k = 1..8), `dout` takes the value of `cmp_hi` sampled at that same edge. The bits therefore leave in order from bit 7 down to bit 0.
- R5: Before decision k, `trial_code` has bit 8-k set to 1, the higher bits equal to the decisions already made, and the lower bits at 0. A `cmp_hi` of 1 keeps the bit under test at 1. A `cmp_hi` of 0 clears it.
- R6: Suppose the comparator reports whether an input code is greater than or equal to `trial_code`. Then after edge 11, `trial_code` equals that input code.
- R7: After edge 11, while `cs_n` stays low, `dout` stays 0 and `trial_code` holds the result, however many further edges arrive.
- R8: Raising `cs_n` in the middle of a frame abandons it. The next frame starts again from edge 1 and gives a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. All state changes on its falling edge. |
| cs_n | input | 1 | Active-low chip select. While high, it holds the block in its clear state. |
| cmp_hi | input | 1 | Comparator result. 1 means the input is at or above the trial level. |
| trial_code | output | 8 | Code driven to the external DAC for the current comparison. |
| dout | output | 1 | Serial data, one decided bit per falling edge. |
| dout_oe | output | 1 | Output enable for `dout`. 0 means the line is released. |

## Verification
Two functions can land on the same falling edge: the clear caused by chip select going high, and a bit decision, including the final one on edge 11. The bench provokes this by raising chip select just before randomly chosen and directed edges of a frame, among them the first, a middle edge and the last. It judges the outcome in three ways. The line must be low and released. The trial code must be back at 8'h80 after that edge. The next full frame must then give the exact input code under a comparator model.

// File: rtl/sar_pkg.sv
package sar_pkg;

    parameter int unsigned SAR_BITS_DEF  = 8;
    parameter int unsigned PREP_EDGES_DEF = 3;

    typedef enum logic [1:0] {
        PH_PREP    = 2'd0,
        PH_RESOLVE = 2'd1,
        PH_DONE    = 2'd2
    } sar_phase_e;

    typedef struct packed {
        sar_phase_e phase;
        logic       decide;
    } sar_step_t;

    // Map an edge count (edges already taken in this frame) to the step
    // performed by the next falling edge.
    function automatic sar_step_t decode_step(input int unsigned cnt,
                                              input int unsigned prep,
                                              input int unsigned bits);
        sar_step_t s;
        if (cnt < prep) begin
            s.phase  = PH_PREP;
            s.decide = 1'b0;
        end else if (cnt < prep + bits) begin
            s.phase  = PH_RESOLVE;
            s.decide = 1'b1;
        end else begin
            s.phase  = PH_DONE;
            s.decide = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/sar_frame_ctr.sv
module sar_frame_ctr #(
    parameter int unsigned FRAME_EDGES = 11,
    parameter int unsigned CNT_W       = 4
) (
    input  logic             sclk,
    input  logic             clr,
    output logic [CNT_W-1:0] edge_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_EDGES);

    logic [CNT_W-1:0] cnt_q;

    // Counts falling edges in a frame and saturates at the frame length,
    // so the frame cannot restart without a clear.
    always_ff @(negedge sclk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign edge_cnt = cnt_q;
endmodule

// File: rtl/sar_bit_resolver.sv
module sar_bit_resolver #(
    parameter int unsigned BITS = 8
) (
    input  logic            sclk,
    input  logic            clr,
    input  logic            decide,
    input  logic            cmp_hi,
    output logic [BITS-1:0] result,
    output logic [BITS-1:0] bit_mask
);
    localparam logic [BITS-1:0] MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};

    logic [BITS-1:0] mask_q;

    // The one-hot mask marks the bit under test and walks toward bit 0.
    always_ff @(negedge sclk) begin
        if (clr) begin
            mask_q <= MSB_ONLY;
        end else if (decide) begin
            mask_q <= mask_q >> 1;
        end
    end

    // Each result bit is set only on the edge that tests it with a high comparator.
    for (genvar i = 0; i < BITS; i++) begin : g_bit
        logic keep_q;
        always_ff @(negedge sclk) begin
            if (clr) begin
                keep_q <= 1'b0;
            end else if (decide && mask_q[i] && cmp_hi) begin
                keep_q <= 1'b1;
            end
        end
        assign result[i] = keep_q;
    end

    assign bit_mask = mask_q;
endmodule

// File: rtl/sar_serial_out.sv
module sar_serial_out (
    input  logic sclk,
    input  logic clr,
    input  logic decide,
    input  logic cmp_hi,
    output logic dout_q
);
    // The decision reaches the line on the same edge that makes it.
    // Idle phases drive 0.
    always_ff @(negedge sclk) begin
        if (clr) begin
            dout_q <= 1'b0;
        end else begin
            dout_q <= decide ? cmp_hi : 1'b0;
        end
    end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_pkg::*;
#(
    parameter int unsigned BITS = SAR_BITS_DEF,
    parameter int unsigned PREP = PREP_EDGES_DEF
) (
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            cmp_hi,
    output logic [BITS-1:0] trial_code,
    output logic            dout,
    output logic            dout_oe
);
    localparam int unsigned FRAME = PREP + BITS;
    localparam int unsigned CNT_W = $clog2(FRAME + 1);

    logic [CNT_W-1:0] edge_cnt;
    logic [BITS-1:0]  result;
    logic [BITS-1:0]  bit_mask;
    logic             dout_q;
    sar_step_t        step;

    sar_frame_ctr #(
        .FRAME_EDGES(FRAME),
        .CNT_W      (CNT_W)
    ) u_ctr (
        .sclk    (sclk),
        .clr     (cs_n),
        .edge_cnt(edge_cnt)
    );

    always_comb begin
        step = decode_step(32'(edge_cnt), PREP, BITS);
    end

    sar_bit_resolver #(
        .BITS(BITS)
    ) u_res (
        .sclk    (sclk),
        .clr     (cs_n),
        .decide  (step.decide),
        .cmp_hi  (cmp_hi),
        .result  (result),
        .bit_mask(bit_mask)
    );

    sar_serial_out u_out (
        .sclk  (sclk),
        .clr   (cs_n),
        .decide(step.decide),
        .cmp_hi(cmp_hi),
        .dout_q(dout_q)
    );

    assign trial_code = result | bit_mask;
    assign dout       = dout_q & ~cs_n;
    assign dout_oe    = ~cs_n;
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
    parameter int unsigned BITS  = 8,
    parameter int unsigned PREP  = 3,
    parameter int unsigned CNT_W = 4
) (
    input logic             sclk,
    input logic             cs_n,
    input logic             cmp_hi,
    input logic [BITS-1:0]  trial_code,
    input logic             dout,
    input logic [CNT_W-1:0] edge_cnt,
    input logic [BITS-1:0]  bit_mask
);
    localparam int unsigned FRAME = PREP + BITS;
    localparam logic [BITS-1:0]  MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};
    localparam logic [CNT_W-1:0] C_PREP   = CNT_W'(PREP);
    localparam logic [CNT_W-1:0] C_FRAME  = CNT_W'(FRAME);

    p_clear_r2: assert property (@(negedge sclk) disable iff ($isunknown(cs_n))
        cs_n |=> (dout == 1'b0 && trial_code == MSB_ONLY && edge_cnt == '0))
        else $error("p_clear_r2");

    p_prep_low_r3: assert property (@(negedge sclk) disable iff (cs_n)
        (edge_cnt < C_PREP) |=> (dout == 1'b0 && trial_code == MSB_ONLY))
        else $error("p_prep_low_r3");

    p_dout_cmp_r4: assert property (@(negedge sclk) disable iff (cs_n)
        (edge_cnt >= C_PREP && edge_cnt < C_FRAME) |=> (dout == $past(cmp_hi)))
        else $error("p_dout_cmp_r4");

    p_keep_bit_r5: assert property (@(negedge sclk) disable iff (cs_n)
        (edge_cnt >= C_PREP && edge_cnt < C_FRAME && cmp_hi)
            |=> ((trial_code & $past(bit_mask)) != '0))
        else $error("p_keep_bit_r5");

    p_mask_onehot_r5: assert property (@(negedge sclk) disable iff (cs_n)
        $onehot0(bit_mask))
        else $error("p_mask_onehot_r5");

    p_done_hold_r7: assert property (@(negedge sclk) disable iff (cs_n)
        (edge_cnt == C_FRAME) |=> (dout == 1'b0 && $stable(trial_code)))
        else $error("p_done_hold_r7");
endmodule

bind sar_serial_seq sar_serial_seq_chk #(
    .BITS (BITS),
    .PREP (PREP),
    .CNT_W(CNT_W)
) u_chk (
    .sclk      (sclk),
    .cs_n      (cs_n),
    .cmp_hi    (cmp_hi),
    .trial_code(trial_code),
    .dout      (dout),
    .edge_cnt  (edge_cnt),
    .bit_mask  (bit_mask)
);

// File: tb/tb_sar_serial_seq.sv
`timescale 1ns/1ps
module tb_sar_serial_seq;
    localparam int PREP  = 3;
    localparam int BITS  = 8;
    localparam int FRAME = PREP + BITS;

    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       cmp_hi = 1'b0;
    logic [7:0] trial_code;
    logic       dout;
    logic       dout_oe;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #2.5 sclk = ~sclk;

    sar_serial_seq dut (
        .sclk      (sclk),
        .cs_n      (cs_n),
        .cmp_hi    (cmp_hi),
        .trial_code(trial_code),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_trial(input int e, input logic [7:0] res);
        if (e <= PREP)       return 8'h80;
        else if (e <= FRAME) return res | (8'h80 >> (e - PREP - 1));
        else                 return res;
    endfunction

    // Called just after a rising edge. abort_at > 0 raises cs_n before that edge.
    task automatic run_frame(input logic [7:0] vin, input bit rnd_cmp,
                             input int abort_at, input int extra);
        logic [7:0] res = 8'h00;
        logic [7:0] et;
        logic       ed;
        int         last;
        cs_n = 1'b0;
        #1 chk("R1 oe in frame", 32'(dout_oe), 32'd1);
        last = (abort_at > 0) ? abort_at - 1 : FRAME + extra;
        for (int e = 1; e <= last; e++) begin
            et = exp_trial(e, res);
            if (e <= PREP)       chk("R3 trial in prep", 32'(trial_code), 32'(et));
            else if (e <= FRAME) chk("R5 trial code", 32'(trial_code), 32'(et));
            else                 chk("R7 trial hold", 32'(trial_code), 32'(et));
            cmp_hi = rnd_cmp ? 1'($urandom % 2) : (vin >= et);
            ed = 1'b0;
            if (e > PREP && e <= FRAME) begin
                ed = cmp_hi;
                if (cmp_hi) res = res | (8'h80 >> (e - PREP - 1));
            end
            @(posedge sclk);
            if (e <= PREP)       chk("R3 dout low in prep", 32'(dout), 32'(ed));
            else if (e <= FRAME) chk("R4 dout bit", 32'(dout), 32'(ed));
            else                 chk("R7 dout low after frame", 32'(dout), 32'(ed));
        end
        if (abort_at == 0 && !rnd_cmp) chk("R6 result", 32'(trial_code), 32'(vin));
        if (abort_at == 0 && rnd_cmp)  chk("R5 result from bits", 32'(trial_code), 32'(res));
        cs_n = 1'b1;
        #1;
        chk("R1 oe released", 32'(dout_oe), 32'd0);
        chk("R1 dout low", 32'(dout), 32'd0);
        @(posedge sclk);
        chk("R2 trial cleared", 32'(trial_code), 32'h80);
        chk("R2 dout cleared", 32'(dout), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge sclk);
        chk("R2 reset trial", 32'(trial_code), 32'h80);
        chk("R1 reset oe", 32'(dout_oe), 32'd0);
        chk("R1 reset dout", 32'(dout), 32'd0);

        // Directed codes at the ends and around mid-scale
        run_frame(8'h00, 1'b0, 0, 0);
        run_frame(8'hFF, 1'b0, 0, 0);
        run_frame(8'h80, 1'b0, 0, 0);
        run_frame(8'h7F, 1'b0, 0, 0);
        run_frame(8'hA5, 1'b0, 0, 6);   // R7: extra edges with cs_n held low

        // R8: abort on the first edge, mid-frame and on the final decision edge
        run_frame(8'h5A, 1'b0, 1, 0);
        run_frame(8'h5A, 1'b0, 6, 0);
        run_frame(8'h5A, 1'b0, FRAME, 0);
        run_frame(8'h3C, 1'b0, 0, 0);   // R8: a full frame after the aborts

        // Random comparator streams (R4, R5)
        for (int i = 0; i < 6; i++) run_frame(8'h00, 1'b1, 0, 0);

        // Random input codes mixed with random aborts (R6, R8)
        for (int i = 0; i < 30; i++) begin
            int ab;
            ab = ($urandom % 4 == 0) ? int'(1 + $urandom % FRAME) : 0;
            run_frame(8'($urandom), 1'b0, ab, int'($urandom % 3));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule